// File: doc/BRIEF.md
# Serial Control Register Slave

This block is the slave end of a three-wire control port. An external microcontroller drives a serial clock and a start strobe, and shares one bidirectional data wire with the slave. The slave turns serial bytes into writes to an internal bank of eight-bit control registers. On request, it shifts register contents back to the master. The bits that other parts of the chip need are decoded straight from the bank: the number of attached field memories, the colour-matrix enable, and the luminance compress and decompress enables.

The serial clock runs far below the system clock. Every serial input passes through a synchroniser, and serial clock edges are found inside the system clock domain. A transfer begins when the strobe is pulsed high. The first byte after the strobe carries a direction flag in bit 7 and a seven-bit start address in bits 6:0. Every byte after that is data for the next address in turn; the address increments modulo 128.

The data wire is split into an input, an output and an output enable, and the pad outside combines them into the tristate line. There is no back-pressure in either direction. The master sets the pace through the serial clock, and the slave keeps up within a few system cycles of each edge.

Top module: `serial_reg_slave`

## Requirements
- R1: After reset every register reads 0x00, all decoded outputs are 0 and the data output enable is low.
- R2: A first byte with bit 7 = 0 starts a write at address bits 6:0. Each later byte is written to the current address, which then increments. Bits arrive MSB first and are sampled on rising serial clock edges.
- R3: A first byte with bit 7 = 1 starts a read at address bits 6:0. The slave returns the register at each address in turn, MSB first. It changes the output bit only on falling serial clock edges, starting with the falling edge that follows the last bit of the first byte.
- R4: The output enable is high only during the data bytes of a read. It stays low during writes and during the first byte, and it drops when the strobe is raised.
- R5: Raising the strobe in the middle of a byte discards the partial byte. The next full byte is taken as a new first byte.
- R6: In register 0x0B, bit 3 shows configuration pin 0 and bit 5 shows configuration pin 1. Writes to those two bits have no effect; the other six bits are ordinary read/write bits.
- R7: The field-memory count output is bits 1:0 of register 0x17. In register 0x26, bit 0 is the matrix enable, bit 1 the compress enable and bit 2 the decompress enable.
- R8: Addresses at or above the bank size (64) ignore writes and read as 0x00. The address wraps from 0x7F to 0x00 during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock from the master |
| ser_strobe_i | input | 1 | Start strobe from the master, active high |
| ser_data_i | input | 1 | Data line as seen at the pad |
| ser_data_o | output | 1 | Data value driven during reads |
| ser_data_oe_o | output | 1 | Enable for the data line driver |
| cfg_pin_i | input | 2 | Configuration pins shown in register 0x0B |
| regs_o | output | 512 | All registers as seen on read, register n at bits 8n+7:8n |
| fm_count_o | output | 2 | Number of field memories |
| matrix_en_o | output | 1 | Colour matrix enable |
| mem_comp_o | output | 1 | Luminance compression enable |
| mem_decomp_o | output | 1 | Luminance decompression enable |

## Verification
The assertions assume that every strobe pulse and every serial clock level lasts longer than the synchroniser delay plus one cycle. This ensures that no edge is missed and that a rising edge never lands in the same cycle as a falling edge. They also assume that the data input is stable around each rising serial clock edge. The stimulus holds each serial clock half-period for ten system cycles and each strobe for six. It changes the data input only while the serial clock is low. It samples returned bits just before the rising edge, well after the slave has updated its output following the previous falling edge.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_WRITE,
    PH_READ
  } phase_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/srs_frame.sv
module srs_frame
  import srs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_s,
  input  logic  strb_s,
  input  logic  din_s,
  input  byte_t rd_data,
  output addr_t rd_addr,
  output logic  wr_en,
  output addr_t wr_addr,
  output byte_t wr_data,
  output logic  dout,
  output logic  oe
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic             sclk_d;
  logic             rise, fall;
  logic [CNT_W-1:0] bit_q, tx_cnt_q;
  byte_t            rx_q, tx_q, nb;
  addr_t            ptr_q;
  phase_e           phase_q;
  logic             last_bit;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign nb       = {rx_q[BYTE_W-2:0], din_s};
  assign last_bit = (bit_q == LAST);

  assign rd_addr = (phase_q == PH_ADDR) ? nb[ADDR_W-1:0] : ptr_q;
  assign wr_en   = rise && !strb_s && last_bit && (phase_q == PH_WRITE);
  assign wr_addr = ptr_q;
  assign wr_data = nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= '0;
      tx_cnt_q <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      phase_q  <= PH_ADDR;
      dout     <= 1'b0;
      oe       <= 1'b0;
    end else if (strb_s) begin
      bit_q    <= '0;
      tx_cnt_q <= '0;
      phase_q  <= PH_ADDR;
      oe       <= 1'b0;
    end else begin
      if (rise) begin
        rx_q  <= nb;
        bit_q <= bit_q + CNT_W'(1);
        if (last_bit) begin
          case (phase_q)
            PH_ADDR: begin
              if (nb[BYTE_W-1]) begin
                phase_q <= PH_READ;
                tx_q    <= rd_data;
                ptr_q   <= nb[ADDR_W-1:0] + ADDR_W'(1);
              end else begin
                phase_q <= PH_WRITE;
                ptr_q   <= nb[ADDR_W-1:0];
              end
            end
            PH_WRITE: ptr_q <= ptr_q + ADDR_W'(1);
            default: ;
          endcase
        end
      end
      if (fall && phase_q == PH_READ) begin
        oe   <= 1'b1;
        dout <= tx_q[BYTE_W-1];
        if (tx_cnt_q == LAST) begin
          tx_q     <= rd_data;
          ptr_q    <= ptr_q + ADDR_W'(1);
          tx_cnt_q <= '0;
        end else begin
          tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
          tx_cnt_q <= tx_cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // R4: driver released once the strobe is seen
  p_oe_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb_s |=> !oe);
  // R4: driver only on in the read data phase
  p_oe_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> phase_q == PH_READ);
  // R3: output bit moves only on a falling serial edge
  p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(dout));
  // R2: one write per received byte
  p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R5: strobe restarts the framing
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb_s |=> (bit_q == '0) && (phase_q == PH_ADDR));
endmodule

// File: rtl/srs_regbank.sv
module srs_regbank
  import srs_pkg::*;
#(
  parameter int   NUM_REGS = 64,
  parameter int   CFG_REG  = 'h0B,
  parameter int   CFG_BIT0 = 3,
  parameter int   CFG_BIT1 = 5,
  parameter int   FM_REG   = 'h17,
  parameter int   CTRL_REG = 'h26
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 cfg_s,
  input  logic                       wr_en,
  input  addr_t                      wr_addr,
  input  byte_t                      wr_data,
  input  addr_t                      rd_addr,
  output byte_t                      rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o,
  output logic [1:0]                 fm_count,
  output logic                       matrix_en,
  output logic                       mem_comp,
  output logic                       mem_decomp
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][BYTE_W-1:0] store_q;
  logic [NUM_REGS-1:0][BYTE_W-1:0] view;
  logic                            wr_hit, rd_hit;

  assign wr_hit = wr_en && (int'(wr_addr) < NUM_REGS);
  assign rd_hit = int'(rd_addr) < NUM_REGS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      store_q <= '0;
    else if (wr_hit) store_q[wr_addr[IDX_W-1:0]] <= wr_data;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_view
    if (g == CFG_REG) begin : g_cfg
      always_comb begin
        view[g]           = store_q[g];
        view[g][CFG_BIT0] = cfg_s[0];
        view[g][CFG_BIT1] = cfg_s[1];
      end
    end else begin : g_plain
      assign view[g] = store_q[g];
    end
  end

  assign rd_data    = rd_hit ? view[rd_addr[IDX_W-1:0]] : '0;
  assign regs_o     = view;
  assign fm_count   = view[FM_REG][1:0];
  assign matrix_en  = view[CTRL_REG][0];
  assign mem_comp   = view[CTRL_REG][1];
  assign mem_decomp = view[CTRL_REG][2];

  // R8: a write outside the bank leaves the storage alone
  p_oob_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) >= NUM_REGS) |=> $stable(store_q));
  // R2: storage changes only after a write strobe
  p_store_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(store_q));
endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
  import srs_pkg::*;
#(
  parameter int NUM_REGS    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_clk_i,
  input  logic                       ser_strobe_i,
  input  logic                       ser_data_i,
  output logic                       ser_data_o,
  output logic                       ser_data_oe_o,
  input  logic [1:0]                 cfg_pin_i,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o,
  output logic [1:0]                 fm_count_o,
  output logic                       matrix_en_o,
  output logic                       mem_comp_o,
  output logic                       mem_decomp_o
);
  localparam int SYNC_W = 5;

  logic [SYNC_W-1:0] raw, synced;
  logic              sclk_s, strb_s, din_s;
  logic [1:0]        cfg_s;
  addr_t             rd_addr, wr_addr;
  byte_t             rd_data, wr_data;
  logic              wr_en;

  assign raw = {cfg_pin_i, ser_clk_i, ser_strobe_i, ser_data_i};
  assign {cfg_s, sclk_s, strb_s, din_s} = synced;

  srs_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (synced)
  );

  srs_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (sclk_s),
    .strb_s  (strb_s),
    .din_s   (din_s),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .dout    (ser_data_o),
    .oe      (ser_data_oe_o)
  );

  srs_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_s      (cfg_s),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .regs_o     (regs_o),
    .fm_count   (fm_count_o),
    .matrix_en  (matrix_en_o),
    .mem_comp   (mem_comp_o),
    .mem_decomp (mem_decomp_o)
  );
endmodule

// File: tb/tb_serial_reg_slave.sv
module tb_serial_reg_slave;
  localparam int NREG = 64;
  localparam int H    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, strb = 1'b0, sdi = 1'b0;
  logic sdo, soe;
  logic [1:0] cfg = 2'b00;
  logic [NREG*8-1:0] regs;
  logic [1:0] fm;
  logic mx, cmp, dcmp;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mirror [128];
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];

  always #4 clk = ~clk;

  serial_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_strobe_i(strb),
    .ser_data_i(sdi), .ser_data_o(sdo), .ser_data_oe_o(soe),
    .cfg_pin_i(cfg), .regs_o(regs), .fm_count_o(fm), .matrix_en_o(mx),
    .mem_comp_o(cmp), .mem_decomp_o(dcmp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_view(input int a);
    logic [7:0] v;
    if (a >= NREG) return 8'h00;
    v = mirror[a];
    if (a == 'h0B) begin v[3] = cfg[0]; v[5] = cfg[1]; end
    return v;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start();
    strb = 1'b1; cyc(6); strb = 1'b0; cyc(6);
  endtask

  task automatic send_bit(input logic b, inout bit oe_seen);
    sdi = b; cyc(H);
    if (soe) oe_seen = 1;
    sclk = 1'b1; cyc(H); sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, inout bit oe_seen);
    for (int i = 7; i >= 0; i--) send_bit(v[i], oe_seen);
  endtask

  // driver: write transaction, updates the expected register image
  task automatic ser_write(input logic [6:0] a, input int n,
                           input logic [7:0] d0, input logic [7:0] d1);
    bit oe_seen = 0;
    logic [6:0] p = a;
    start();
    send_byte({1'b0, a}, oe_seen);
    for (int k = 0; k < n; k++) begin
      send_byte(k == 0 ? d0 : d1, oe_seen);
      if (int'(p) < NREG) mirror[p] = (k == 0 ? d0 : d1);
      p = p + 7'd1;
    end
    cyc(4);
    chk("R4 enable low during write", {31'd0, oe_seen}, 0);
  endtask

  // driver: read transaction, expected bytes go to the scoreboard
  task automatic ser_read(input logic [6:0] a, input int n);
    bit dummy = 0;
    bit oe_ok = 1;
    logic [6:0] p = a;
    logic [7:0] got;
    start();
    send_byte({1'b1, a}, dummy);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(exp_view(int'(p)));
      p = p + 7'd1;
      for (int i = 7; i >= 0; i--) begin
        cyc(H);
        got[i] = sdo;
        if (!soe) oe_ok = 0;
        sclk = 1'b1; cyc(H); sclk = 1'b0;
      end
      act_q.push_back(got);
    end
    chk("R4 enable high during read data", {31'd0, oe_ok}, 1);
    strb = 1'b1; cyc(6);
    chk("R4 enable drops on strobe", {31'd0, soe}, 0);
    strb = 1'b0; cyc(4);
  endtask

  task automatic chk_all(input string req);
    logic ok = 1;
    for (int a = 0; a < NREG; a++)
      if (regs[a*8 +: 8] !== exp_view(a)) ok = 0;
    chk(req, {31'd0, ok}, 1);
  endtask

  // monitor: compare read-back bytes against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] a, e;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL R3 read data actual=%0h expected=%0h", a, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit d = 0;
    for (int a = 0; a < 128; a++) mirror[a] = 8'h00;
    cyc(5);
    // R1: reset state
    chk("R1 enable", {31'd0, soe}, 0);
    chk("R1 decoded", {27'd0, fm, mx, cmp, dcmp}, 0);
    chk("R1 registers zero", {31'd0, regs == '0}, 1);
    rst_n = 1'b1;
    cyc(5);

    // R2 / R7: auto-incremented writes and decoded bits
    ser_write(7'h17, 2, 8'h03, 8'h5A);
    chk("R7 field memory count", {30'd0, fm}, 2'd3);
    chk("R2 second byte at next address", {24'd0, regs[8'h18*8 +: 8]}, 8'h5A);
    ser_write(7'h26, 1, 8'h05, 8'h00);
    chk("R7 matrix/comp/decomp 101", {29'd0, mx, cmp, dcmp}, 3'b101);
    ser_write(7'h26, 1, 8'h02, 8'h00);
    chk("R7 matrix/comp/decomp 010", {29'd0, mx, cmp, dcmp}, 3'b010);
    chk_all("R2 register image");

    // R3: read back across consecutive addresses
    ser_read(7'h17, 3);
    ser_read(7'h26, 1);

    // R6: configuration pins in register 0x0B
    cfg = 2'b01; cyc(6);
    ser_write(7'h0B, 1, 8'hFF, 8'h00);
    chk("R6 cfg overlay 01", {24'd0, regs[8'h0B*8 +: 8]}, 8'hDF);
    ser_read(7'h0B, 1);
    cfg = 2'b10; cyc(6);
    ser_write(7'h0B, 1, 8'h00, 8'h00);
    chk("R6 cfg overlay 10", {24'd0, regs[8'h0B*8 +: 8]}, 8'h20);
    ser_read(7'h0B, 1);

    // R5: strobe mid data byte and mid first byte
    ser_write(7'h10, 1, 8'hAA, 8'h00);
    for (int i = 0; i < 3; i++) send_bit(1'b1, d);
    ser_write(7'h11, 1, 8'h55, 8'h00);
    chk("R5 byte after mid-data strobe", {24'd0, regs[8'h11*8 +: 8]}, 8'h55);
    start();
    for (int i = 0; i < 4; i++) send_bit(1'b1, d);
    ser_write(7'h12, 1, 8'h66, 8'h00);
    chk("R5 byte after mid-address strobe", {24'd0, regs[8'h12*8 +: 8]}, 8'h66);
    chk_all("R5 register image");

    // R8: end of bank, out-of-range and address wrap
    ser_write(7'h3F, 2, 8'h77, 8'h99);
    chk("R8 last register written", {24'd0, regs[8'h3F*8 +: 8]}, 8'h77);
    ser_write(7'h7F, 2, 8'h11, 8'h3C);
    chk("R8 wrap to address 0", {24'd0, regs[7:0]}, 8'h3C);
    chk_all("R8 out-of-range writes ignored");
    ser_read(7'h7F, 2);
    ser_read(7'h3E, 3);

    cyc(20);
    chk("R3 scoreboard drained", exp_q.size() + act_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule